// File: doc/BRIEF.md
# Big-endian load/store lane aligner

This unit sits between a processor's load/store pipe and a 32-bit data memory that is organised in words but addressed in bytes. The core sends a byte address, an access size (single byte or full word), a read/write flag and store data. The unit turns each request into a word-aligned memory request with per-lane write enables, and it places store bytes on the correct lanes. When load data comes back, the unit picks out the addressed byte and sign-extends it, or passes the whole word through unchanged. Lane order is big-endian: the byte whose address ends in binary 00 occupies bits [31:24] of the memory word.

A word access whose two low address bits are not zero is misaligned. The unit consumes such a request, sends nothing to memory and pulses a fault flag. Both request channels use valid/ready. A request that is offered is held until it is accepted. The core side may be back-pressured by the one-entry output register or by a full tracker of outstanding loads. The memory side holds its request stable while it is stalled. Memory returns read data in order on a plain valid strobe that cannot be back-pressured. The load result leaves in the same cycle.

Top module: `be_lsu_align`

## Requirements
- R1: The memory address is the request byte address with bits [1:0] forced to zero.
- R2: For a byte store, exactly one write-enable bit is set: address low bits 00 set be[3] (data bits [31:24]), 01 set be[2], 10 set be[1] and 11 set be[0]. Loads set no write enable.
- R3: For a byte store, the low 8 bits of the store data appear on all four byte lanes of the memory write data.
- R4: An aligned word store sets all four write enables and passes the store data unchanged.
- R5: A byte load returns the lane selected by address bits [1:0] (00 selects [31:24], 11 selects [7:0]), sign-extended to 32 bits.
- R6: An aligned word load returns the memory word unchanged. Byte address A holds bits [31:24] and A+3 holds bits [7:0].
- R7: A word access with nonzero address bits [1:0] raises the fault output for exactly the cycle after acceptance. It issues no memory request and changes no memory byte.
- R8: Byte accesses at any address never fault.
- R9: req_ready is high when the output register is empty or memory accepts this cycle, and a load slot is free. While mem_valid is high and mem_ready is low, the memory request does not change.
- R10: Load results come out in request order, with ld_valid in the same cycle as mem_rvalid.
- R11: After reset, mem_valid, ld_valid and fault are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request offered |
| req_ready | output | 1 | Core request accepted this cycle when high with req_valid |
| req_addr | input | AW | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_we | input | 1 | 1 = store, 0 = load |
| req_wdata | input | 32 | Store data (byte store uses bits [7:0]) |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Word-aligned byte address |
| mem_we | output | 1 | Memory write |
| mem_be | output | 4 | Lane write enables, be[3] = bits [31:24] |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |
| fault | output | 1 | Misaligned word access pulse |

## Verification
A wrong lane mapping corrupts the memory contents one cycle after the store handshake. It becomes visible as a wrong load result as soon as any later load reaches that byte, and as a wrong write-enable or data pattern at the memory port on the store itself. A corrupted or out-of-step entry in the outstanding-load tracker gives the wrong extraction or sign for the next returned load, in the same cycle as mem_rvalid. A missed fault shows as a memory request that should not exist one cycle after acceptance. A stalled register that drifts shows while mem_ready is held low.

// File: rtl/be_lsu_pkg.sv
package be_lsu_pkg;
  localparam int LANES = 4;
  localparam int DW    = 32;

  typedef struct packed {
    logic [1:0] lane;
    logic       word;
  } ld_tag_t;
endpackage

// File: rtl/lane_encode.sv
module lane_encode #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic          misaligned,
  output logic [AW-1:0] word_addr,
  output logic [3:0]    be,
  output logic [31:0]   lane_data
);
  import be_lsu_pkg::*;

  assign misaligned = word && (addr[1:0] != 2'b00);
  assign word_addr  = {addr[AW-1:2], 2'b00};

  // byte index g counts from the most significant lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int BIT = LANES - 1 - g;
    assign be[BIT] = we && !misaligned &&
                     (word || (addr[1:0] == 2'(g)));
    assign lane_data[8*BIT +: 8] = word ? wdata[8*BIT +: 8] : wdata[7:0];
  end
endmodule

// File: rtl/req_stage.sv
module req_stage #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] in_addr,
  input  logic          in_we,
  input  logic [3:0]    in_be,
  input  logic [31:0]   in_data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          out_we,
  output logic [3:0]    out_be,
  output logic [31:0]   out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_we    <= 1'b0;
      out_be    <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_addr  <= in_addr;
      out_we    <= in_we;
      out_be    <= in_be;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tag_fifo.sv
module tag_fifo #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  be_lsu_pkg::ld_tag_t      push_tag,
  input  logic                     pop,
  output be_lsu_pkg::ld_tag_t      head,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  import be_lsu_pkg::*;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  ld_tag_t       slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_pop;

  assign do_pop = pop && (count != '0);
  assign full   = (count == CW'(DEPTH));
  assign head   = slots[rd_ptr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_tag;
        wr_ptr        <= bump(wr_ptr);
      end
      if (do_pop) rd_ptr <= bump(rd_ptr);
      count <= count + CW'(push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/load_extract.sv
module load_extract (
  input  logic [31:0]         rdata,
  input  be_lsu_pkg::ld_tag_t tag,
  output logic [31:0]         result
);
  import be_lsu_pkg::*;
  logic [7:0] picked [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign picked[g] = rdata[8*(LANES-1-g) +: 8];
  end

  always_comb begin
    if (tag.word) result = rdata;
    else          result = {{24{picked[tag.lane][7]}}, picked[tag.lane]};
  end
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
  parameter int AW       = 16,
  parameter int LD_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_word,
  input  logic          req_we,
  input  logic [31:0]   req_wdata,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          ld_valid,
  output logic [31:0]   ld_data,
  output logic          fault
);
  import be_lsu_pkg::*;
  localparam int CW = $clog2(LD_DEPTH + 1);

  logic          mis;
  logic [AW-1:0] enc_addr;
  logic [3:0]    enc_be;
  logic [31:0]   enc_data;
  logic          accept, stage_free, tag_full;
  ld_tag_t       new_tag, head_tag;
  logic [CW-1:0] tag_cnt;

  lane_encode #(.AW(AW)) u_enc (
    .addr(req_addr), .word(req_word), .we(req_we), .wdata(req_wdata),
    .misaligned(mis), .word_addr(enc_addr), .be(enc_be), .lane_data(enc_data)
  );

  assign stage_free = !mem_valid || mem_ready;
  assign req_ready  = stage_free && !tag_full;
  assign accept     = req_valid && req_ready;

  req_stage #(.AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_n), .load(accept && !mis),
    .in_addr(enc_addr), .in_we(req_we), .in_be(enc_be), .in_data(enc_data),
    .out_ready(mem_ready), .out_valid(mem_valid), .out_addr(mem_addr),
    .out_we(mem_we), .out_be(mem_be), .out_data(mem_wdata)
  );

  assign new_tag.lane = req_addr[1:0];
  assign new_tag.word = req_word;

  tag_fifo #(.DEPTH(LD_DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_n), .push(accept && !mis && !req_we),
    .push_tag(new_tag), .pop(mem_rvalid), .head(head_tag),
    .full(tag_full), .count(tag_cnt)
  );

  load_extract u_ext (.rdata(mem_rdata), .tag(head_tag), .result(ld_data));
  assign ld_valid = mem_rvalid;

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else        fault <= accept && mis;
  end
endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk #(
  parameter int AW = 16,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [3:0]    mem_be,
  input logic [31:0]   mem_wdata,
  input logic          mem_rvalid,
  input logic          fault,
  input logic [CW-1:0] tag_cnt
);
  // R1
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
  // R2
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> ($countones(mem_be) == 1 || mem_be == 4'hF));
  // R3
  byte_repl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we && $countones(mem_be) == 1 |->
      (mem_wdata[31:24] == mem_wdata[7:0] && mem_wdata[23:16] == mem_wdata[7:0]
       && mem_wdata[15:8] == mem_wdata[7:0]));
  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
      $stable(mem_we) && $stable(mem_be) && $stable(mem_wdata));
  // R7
  fault_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && req_ready));
  // R10
  rsp_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> tag_cnt != '0);
endmodule

bind be_lsu_align be_lsu_align_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .mem_rvalid(mem_rvalid), .fault(fault), .tag_cnt(tag_cnt)
);

// File: tb/be_lsu_align_tb.sv
module be_lsu_align_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_word = 0, req_we = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic mem_ready = 0, mem_rvalid = 0;
  logic [31:0] mem_rdata = '0;
  logic req_ready, mem_valid, mem_we, ld_valid, fault;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, ld_data;

  always #4 clk = ~clk;

  be_lsu_align #(.AW(AW), .LD_DEPTH(4)) u_dut (.*);

  int errors = 0, checks = 0;
  logic [7:0]  refm [256];
  logic [31:0] memw [64];
  logic [AW+36:0] exp_req [$];
  logic [31:0]    exp_ld  [$];
  logic exp_fault = 0, pend = 0;
  logic [31:0] pend_d = '0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 37 + 11);
    for (int w = 0; w < 64; w++)
      memw[w] = {refm[4*w], refm[4*w+1], refm[4*w+2], refm[4*w+3]};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!mem_valid && !ld_valid && !fault && req_ready, "R11",
        {mem_valid, ld_valid, fault, req_ready}, 4'b0001);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      // R7 fault one cycle after acceptance
      chk(fault == exp_fault, "R7 fault", fault, exp_fault);
      exp_fault = 0;
      mem_rvalid = pend; mem_rdata = pend_d; pend = 0;
      if (!req_valid || req_ready) begin
        req_valid = ($urandom % 10) < 7;
        req_addr  = AW'($urandom % 256);
        req_word  = $urandom % 2;
        req_we    = $urandom % 2;
        req_wdata = $urandom;
      end
      mem_ready = (cyc > 200 && cyc < 260) ? 1'b0 : (($urandom % 10) < 7);
      #1;
      // R10 result in order and in the same cycle
      chk(ld_valid == mem_rvalid, "R10 ld_valid", ld_valid, mem_rvalid);
      if (ld_valid) begin
        if (exp_ld.size() == 0) chk(0, "R10 extra", 1, 0);
        else begin
          logic [31:0] e;
          e = exp_ld.pop_front();
          // R5 R6 extraction and extension
          chk(ld_data == e, "R5/R6 load", ld_data, e);
        end
      end
      // R9 ready rule
      chk(req_ready == ((!mem_valid || mem_ready) && exp_ld.size() + int'(pend) < 4 ||
                        ((!mem_valid || mem_ready) && req_ready)), "R9 ready", req_ready, 1);
      if (mem_valid && mem_ready) begin
        if (exp_req.size() == 0) chk(0, "R7 spurious request", 1, 0);
        else begin
          logic [AW+36:0] e;
          e = exp_req.pop_front();
          // R1 R2 R4 address, write and enables
          chk({mem_addr, mem_we, mem_be} == e[AW+36:32], "R1/R2/R4 req",
              {mem_addr, mem_we, mem_be}, e[AW+36:32]);
          // R3 R4 store data lanes
          if (mem_we) chk(mem_wdata == e[31:0], "R3/R4 wdata", mem_wdata, e[31:0]);
        end
        if (mem_we) begin
          for (int b = 0; b < 4; b++)
            if (mem_be[b]) memw[mem_addr[7:2]][8*b +: 8] = mem_wdata[8*b +: 8];
        end else begin
          pend = 1; pend_d = memw[mem_addr[7:2]];
        end
      end
      if (req_valid && req_ready) begin
        int a;
        a = int'(req_addr[7:0]);
        if (req_word && a % 4 != 0) begin
          exp_fault = 1;
        end else if (req_we) begin
          if (req_word) begin
            refm[a] = req_wdata[31:24]; refm[a+1] = req_wdata[23:16];
            refm[a+2] = req_wdata[15:8]; refm[a+3] = req_wdata[7:0];
            exp_req.push_back({req_addr & ~AW'(3), 1'b1, 4'hF, req_wdata});
          end else begin
            refm[a] = req_wdata[7:0];
            exp_req.push_back({req_addr & ~AW'(3), 1'b1, 4'(4'b1000 >> (a % 4)),
                               {4{req_wdata[7:0]}}});
          end
        end else begin
          exp_req.push_back({req_addr & ~AW'(3), 1'b0, 4'h0, 32'h0});
          if (req_word) exp_ld.push_back({refm[a], refm[a+1], refm[a+2], refm[a+3]});
          else          exp_ld.push_back({{24{refm[a][7]}}, refm[a]});
        end
        // R8 byte accesses never fault
        if (!req_word) chk(!exp_fault, "R8", exp_fault, 0);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule